// File: doc/BRIEF.md
# Power-on strap capture and configuration select

This block owns a group of dual-use pins during and after power-on. While the power-on window is open it treats the pins as inputs. On the last reference-clock edge of that window it records their levels in a strap latch: a frequency-select code, a 24/48 MHz select bit and a two-bit pin-mode pair. From the next cycle on, the pins serve as clock outputs. Their output enables follow the window-done flag, a per-output enable from the register file, and an asynchronous active-low power-down input.

After the window closes, a source bit held in the block decides where the effective frequency-select code comes from. The bit resets to 0, which selects the strap latch. Setting it to 1 selects a programmable register field. That register field, and the 24/48 select register bit, are loaded from the strap latch at the moment of capture. The captured mode pair steers three shared pins between a link clock and a PCI clock. Pad electrical behaviour and clock synthesis live elsewhere.

Top module: `strap_cfg_top`

## Requirements
- R1: After `rst_ni` is released, `strap_done_o` rises after exactly `POR_CYCLES` rising clock edges and then stays high until the next reset. While it is low, every bit of `pin_oe_o` is 0.
- R2: The strap inputs (`fs_strap_i`, `sel24_strap_i`, `mode_strap_i`) are sampled on the last edge of the window only. Changes to them before that edge, or at any time after it, do not alter `fs_code_o`, `clk24_sel_o` or `link_sel_o`.
- R3: The source bit resets to 0. While it is 0, `fs_code_o` equals the latched strap code, even after the register code has been rewritten.
- R4: While the source bit is 1, `fs_code_o` equals the register frequency-select field.
- R5: At capture, the register frequency-select field and the register 24/48 bit take the latched strap values. So setting the source bit without writing the field leaves `fs_code_o` at the strap code.
- R6: `clk24_sel_o` drives the register 24/48 bit (0 selects 48 MHz, 1 selects 24 MHz). The pulse `set_we_i` writes it from `cfg_sel24_i`, together with the field from `cfg_fs_i`. The pulse `src_we_i` writes the source bit from `cfg_src_i`. A write is visible after the next edge.
- R7: Register and source writes made while `strap_done_o` is 0 are ignored.
- R8: Bit i of `link_sel_o` is 1 when shared pin i carries the link clock and 0 when it carries a PCI clock. The mode is {`mode_strap_i[1]`, `mode_strap_i[0]`}. The table is: 00 gives 3'b011, 01 gives 3'b111, 10 gives 3'b000, 11 gives 3'b001.
- R9: `pin_oe_o` = `out_en_i` AND `strap_done_o` AND `pd_ni`. Power-down acts without waiting for a clock edge.
- R10: Asserting `rst_ni` at any time clears the done flag, the latch and the source bit, and restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pd_ni | input | 1 | Asynchronous active-low power-down |
| fs_strap_i | input | FS_W | Frequency-select strap levels |
| sel24_strap_i | input | 1 | 24/48 select strap level |
| mode_strap_i | input | 2 | Pin-mode strap pair |
| src_we_i | input | 1 | Write strobe for the source bit |
| cfg_src_i | input | 1 | Source bit write data (1 selects the register) |
| set_we_i | input | 1 | Write strobe for the frequency field and the 24/48 bit |
| cfg_fs_i | input | FS_W | Frequency field write data |
| cfg_sel24_i | input | 1 | 24/48 bit write data |
| out_en_i | input | N_OUT | Per-output enable bits |
| strap_done_o | output | 1 | Power-on window finished |
| fs_code_o | output | FS_W | Effective frequency-select code |
| clk24_sel_o | output | 1 | 24/48 select (1 selects 24 MHz) |
| link_sel_o | output | 3 | Per shared pin: 1 selects the link clock |
| pin_oe_o | output | N_OUT | Output enables of the shared pins |

## Verification
Suppose the strap latch samples on the wrong edge, or keeps sampling after the window. Then `fs_code_o` and `link_sel_o` take a value different from the straps held at the final edge, and the error shows on the first cycle after `strap_done_o` rises. Straps changed after that point expose continued sampling on the next cycle. A source bit or register field that accepts writes during the window, or that misses its load at capture, shows on `fs_code_o` one edge after the source bit is set. A wrong window counter moves the rise of `strap_done_o` and `pin_oe_o` off its exact cycle. A broken power-down path shows on `pin_oe_o` within the same cycle, with no clock edge needed.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int unsigned SHARED_PINS = 3;

  typedef enum logic [1:0] {
    MODE_LLP = 2'b00,
    MODE_LLL = 2'b01,
    MODE_PPP = 2'b10,
    MODE_LPP = 2'b11
  } pin_mode_e;

  // bit i = 1: shared pin i carries the link clock
  function automatic logic [SHARED_PINS-1:0] steer_map(input pin_mode_e m);
    case (m)
      MODE_LLP: steer_map = 3'b011;
      MODE_LLL: steer_map = 3'b111;
      MODE_PPP: steer_map = 3'b000;
      default:  steer_map = 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned FS_W       = 5,
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_strap_i,
  input  logic            sel_strap_i,
  input  logic [1:0]      mode_strap_i,
  output logic            done_o,
  output logic            cap_o,
  output logic [FS_W-1:0] fs_q_o,
  output logic            sel_q_o,
  output logic [1:0]      mode_q_o
);
  localparam int unsigned CNT_W = $clog2(POR_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign cap_o = !done_o && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      done_o   <= 1'b0;
      fs_q_o   <= '0;
      sel_q_o  <= 1'b0;
      mode_q_o <= 2'b00;
    end else if (!done_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cap_o) begin
        done_o   <= 1'b1;
        fs_q_o   <= fs_strap_i;
        sel_q_o  <= sel_strap_i;
        mode_q_o <= mode_strap_i;
      end
    end
  end

  // R1
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (fs_q_o == $past(fs_strap_i)) && (mode_q_o == $past(mode_strap_i)));
  // R2
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(done_o) |-> $stable(fs_q_o) && $stable(sel_q_o) && $stable(mode_q_o));
endmodule

// File: rtl/cfg_select.sv
module cfg_select #(
  parameter int unsigned FS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic            cap_i,
  input  logic [FS_W-1:0] strap_fs_i,
  input  logic            strap_sel_i,
  input  logic [FS_W-1:0] cap_fs_i,
  input  logic            cap_sel_i,
  input  logic            src_we_i,
  input  logic            src_i,
  input  logic            set_we_i,
  input  logic [FS_W-1:0] fs_i,
  input  logic            sel24_i,
  output logic [FS_W-1:0] fs_code_o,
  output logic            clk24_sel_o
);
  logic [FS_W-1:0] reg_fs_q;
  logic            reg_sel_q;
  logic            src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_fs_q  <= '0;
      reg_sel_q <= 1'b0;
      src_q     <= 1'b0;
    end else if (cap_i) begin
      // register defaults come from the straps being captured
      reg_fs_q  <= cap_fs_i;
      reg_sel_q <= cap_sel_i;
    end else if (done_i) begin
      if (set_we_i) begin
        reg_fs_q  <= fs_i;
        reg_sel_q <= sel24_i;
      end
      if (src_we_i) src_q <= src_i;
    end
  end

  assign fs_code_o   = src_q ? reg_fs_q : strap_fs_i;
  assign clk24_sel_o = reg_sel_q;

  // R7
  src_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> !src_q);
  // R3
  strap_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_q |-> fs_code_o == strap_fs_i);
  // R5
  reg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> reg_fs_q == strap_fs_i && reg_sel_q == strap_sel_i);
endmodule

// File: rtl/pin_steer.sv
module pin_steer
  import strap_cfg_pkg::*;
#(
  parameter int unsigned N_OUT = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   done_i,
  input  logic                   pd_ni,
  input  logic [1:0]             mode_i,
  input  logic [N_OUT-1:0]       out_en_i,
  output logic [SHARED_PINS-1:0] link_sel_o,
  output logic [N_OUT-1:0]       pin_oe_o
);
  assign link_sel_o = steer_map(pin_mode_e'(mode_i));

  for (genvar g = 0; g < N_OUT; g++) begin : g_oe
    assign pin_oe_o[g] = out_en_i[g] & done_i & pd_ni;
  end

  // R9
  pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> pin_oe_o == '0);
  // R1
  window_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> pin_oe_o == '0);
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_cfg_pkg::*;
#(
  parameter int unsigned FS_W       = 5,
  parameter int unsigned N_OUT      = 8,
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pd_ni,
  input  logic [FS_W-1:0]        fs_strap_i,
  input  logic                   sel24_strap_i,
  input  logic [1:0]             mode_strap_i,
  input  logic                   src_we_i,
  input  logic                   cfg_src_i,
  input  logic                   set_we_i,
  input  logic [FS_W-1:0]        cfg_fs_i,
  input  logic                   cfg_sel24_i,
  input  logic [N_OUT-1:0]       out_en_i,
  output logic                   strap_done_o,
  output logic [FS_W-1:0]        fs_code_o,
  output logic                   clk24_sel_o,
  output logic [SHARED_PINS-1:0] link_sel_o,
  output logic [N_OUT-1:0]       pin_oe_o
);
  logic            cap;
  logic [FS_W-1:0] lat_fs;
  logic            lat_sel;
  logic [1:0]      lat_mode;

  strap_latch #(.FS_W(FS_W), .POR_CYCLES(POR_CYCLES)) latch_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fs_strap_i  (fs_strap_i),
    .sel_strap_i (sel24_strap_i),
    .mode_strap_i(mode_strap_i),
    .done_o      (strap_done_o),
    .cap_o       (cap),
    .fs_q_o      (lat_fs),
    .sel_q_o     (lat_sel),
    .mode_q_o    (lat_mode)
  );

  cfg_select #(.FS_W(FS_W)) sel_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (strap_done_o),
    .cap_i      (cap),
    .strap_fs_i (lat_fs),
    .strap_sel_i(lat_sel),
    .cap_fs_i   (fs_strap_i),
    .cap_sel_i  (sel24_strap_i),
    .src_we_i   (src_we_i),
    .src_i      (cfg_src_i),
    .set_we_i   (set_we_i),
    .fs_i       (cfg_fs_i),
    .sel24_i    (cfg_sel24_i),
    .fs_code_o  (fs_code_o),
    .clk24_sel_o(clk24_sel_o)
  );

  pin_steer #(.N_OUT(N_OUT)) steer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (strap_done_o),
    .pd_ni     (pd_ni),
    .mode_i    (lat_mode),
    .out_en_i  (out_en_i),
    .link_sel_o(link_sel_o),
    .pin_oe_o  (pin_oe_o)
  );
endmodule

// File: tb/strap_cfg_top_tb_top.sv
module strap_cfg_top_tb_top;
  localparam int FS_W = 5;
  localparam int N_OUT = 8;
  localparam int POR = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0, pd_ni = 1'b1;
  logic [FS_W-1:0] fs_strap = '0, cfg_fs = '0;
  logic sel_strap = 1'b0, src_we = 1'b0, cfg_src = 1'b0, set_we = 1'b0, cfg_sel = 1'b0;
  logic [1:0] mode_strap = 2'b00;
  logic [N_OUT-1:0] out_en = '1;
  logic done_o, sel_o;
  logic [FS_W-1:0] fs_o;
  logic [2:0] link_o;
  logic [N_OUT-1:0] oe_o;

  strap_cfg_top #(.FS_W(FS_W), .N_OUT(N_OUT), .POR_CYCLES(POR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni),
    .fs_strap_i(fs_strap), .sel24_strap_i(sel_strap), .mode_strap_i(mode_strap),
    .src_we_i(src_we), .cfg_src_i(cfg_src), .set_we_i(set_we),
    .cfg_fs_i(cfg_fs), .cfg_sel24_i(cfg_sel), .out_en_i(out_en),
    .strap_done_o(done_o), .fs_code_o(fs_o), .clk24_sel_o(sel_o),
    .link_sel_o(link_o), .pin_oe_o(oe_o)
  );

  typedef struct {
    string            req;
    logic             done;
    logic [FS_W-1:0]  fs;
    logic             sel;
    logic [2:0]       link;
    logic [N_OUT-1:0] oe;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  bit m_done, m_src, m_lsel, m_csel;
  int m_cnt;
  logic [FS_W-1:0] m_lfs, m_cfs;
  logic [1:0] m_lmode;

  function automatic logic [2:0] ref_link(input logic [1:0] m);
    case (m)
      2'b00: return 3'b011;
      2'b01: return 3'b111;
      2'b10: return 3'b000;
      default: return 3'b001;
    endcase
  endfunction

  task automatic model_reset();
    m_done = 0; m_src = 0; m_lsel = 0; m_csel = 0; m_cnt = 0;
    m_lfs = '0; m_cfs = '0; m_lmode = 2'b00;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_ni) begin
      if (!m_done) begin
        m_cnt++;
        if (m_cnt == POR) begin
          m_done = 1; m_lfs = fs_strap; m_lsel = sel_strap; m_lmode = mode_strap;
          m_cfs = fs_strap; m_csel = sel_strap;
        end
      end else begin
        if (set_we) begin m_cfs = cfg_fs; m_csel = cfg_sel; end
        if (src_we) m_src = cfg_src;
      end
    end
    #1;
  endtask

  task automatic expect_now(input string req);
    exp_t e;
    e.req  = req;
    e.done = m_done;
    e.fs   = m_src ? m_cfs : m_lfs;
    e.sel  = m_csel;
    e.link = ref_link(m_lmode);
    e.oe   = (m_done && pd_ni) ? out_en : '0;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (done_o !== e.done || fs_o !== e.fs || sel_o !== e.sel ||
          link_o !== e.link || oe_o !== e.oe) begin
        fails++;
        $display("FAIL %s: actual done=%0b fs=%h sel=%0b link=%b oe=%h expected done=%0b fs=%h sel=%0b link=%b oe=%h",
                 e.req, done_o, fs_o, sel_o, link_o, oe_o, e.done, e.fs, e.sel, e.link, e.oe);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    step(); step();
    expect_now("R10 reset state");
    step();
    rst_ni = 1'b1;
    fs_strap = 5'h03; sel_strap = 1'b0; mode_strap = 2'b11;
    for (int i = 1; i <= POR; i++) begin
      step();
      if (i == 3) begin src_we = 1; cfg_src = 1; set_we = 1; cfg_fs = 5'h1F; cfg_sel = 0; end
      if (i == 4) begin src_we = 0; set_we = 0; end
      if (i == POR - 1) begin fs_strap = 5'h16; sel_strap = 1'b1; mode_strap = 2'b01; end
      if (i == POR) expect_now("R1 done edge");
      else if (i == 4) expect_now("R7 write in window");
      else expect_now("R1 window");
    end
    // R2: strap changes after capture
    fs_strap = 5'h09; sel_strap = 1'b0; mode_strap = 2'b10;
    for (int i = 0; i < 3; i++) begin step(); expect_now("R2 straps ignored"); end
    // R5: source bit set, field untouched
    src_we = 1; cfg_src = 1;
    step(); src_we = 0; expect_now("R5 register from straps");
    src_we = 1; cfg_src = 0;
    step(); src_we = 0; expect_now("R3 source back to latch");
    set_we = 1; cfg_fs = 5'h0A; cfg_sel = 1'b0;
    step(); set_we = 0; expect_now("R3 latch despite write / R6 sel 48");
    src_we = 1; cfg_src = 1;
    step(); src_we = 0; expect_now("R4 register code");
    set_we = 1; cfg_fs = 5'h11; cfg_sel = 1'b1;
    step(); set_we = 0; expect_now("R6 sel 24 and R4 new code");
    // R9
    step(); out_en = 8'hA5; expect_now("R9 enable pattern");
    step(); pd_ni = 1'b0; expect_now("R9 power-down");
    step(); out_en = 8'h3C; expect_now("R9 power-down holds");
    step(); pd_ni = 1'b1; expect_now("R9 power-up");
    // R8 / R10: each mode through a fresh window
    for (int m = 0; m < 4; m++) begin
      step(); rst_ni = 1'b0; model_reset(); expect_now("R10 reset again");
      step(); rst_ni = 1'b1; mode_strap = 2'(m); fs_strap = 5'(m + 4); sel_strap = m[0];
      for (int i = 1; i <= POR; i++) begin
        step();
        if (i == POR) expect_now("R8 steering table");
      end
      step(); expect_now("R8 steering hold");
    end
    repeat (4) step();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule